// File: doc/BRIEF.md
# Test-Access Host Register File

This block is the host-side register file of a test-access controller. A host reaches it through a byte-wide register bus. A 3-bit address combines with a read/write select to reach sixteen distinct access slots. The read map and the write map differ at several addresses. Writes reach the serial shifter buffers (scan data out, scan data in, two mode-select streams), the 32-bit event counter and three 8-bit mode registers. Reads return the scan-data-in buffer, the mode registers and four counter readback bytes.

The third mode register holds three command bits that clear themselves:

- **Status refresh** issues one internal pulse, which copies the live counter into the readback bytes.
- **Soft reset** clears every function except the host register bank.
- **Single step** advances the counter once without emitting a scan clock pulse.

The counter also advances on an external tick while counting is enabled. Each such tick is passed on as a scan clock pulse.

The bus is a plain register strobe with no back-pressure. A write takes effect at the clock edge where `acc` is high and `rnw` is low. Read data is combinational from `addr`.

Top module: `tap_host_regs`

## Requirements
- R1: While `rst_n` is low, every register, buffer, counter, byte pointer and readback byte is held at zero. After release, every read address returns 0 until the first write.
- R2: The write map is as follows:
  - address 0 loads `tdo_buf`
  - address 1 loads the scan-data-in buffer
  - address 2 loads `tms0_buf`
  - address 3 loads `tms1_buf`
  - address 4 loads one counter byte
  - addresses 5, 6 and 7 load mode registers A, B and C.
- R3: The read map is as follows:
  - address 0 returns readback byte 1 (count bits 15:8)
  - address 1 returns the scan-data-in buffer
  - address 2 returns readback byte 2 (bits 23:16)
  - address 3 returns readback byte 3 (bits 31:24)
  - address 4 returns readback byte 0 (bits 7:0)
  - addresses 5 to 7 return mode A, mode B and mode C.
- R4: A write to address 4 replaces the counter byte selected by an internal pointer. The pointer starts at lane 0 (bits 7:0), steps to the next higher lane and wraps to lane 0 after lane 3.
- R5: Writing 1 to mode C bit 2 (status refresh) raises `upd_pulse` for exactly the following cycle. At the end of that cycle the counter value is copied into the readback bytes. Bit 2 always reads as 0.
- R6: Writing 1 to mode C bit 1 (soft reset) makes the bit read 1 for the following cycle. At the end of that cycle the following are cleared and the bit returns to 0:
  - the shifter buffers
  - the counter
  - the byte pointer
  - the readback bytes.

  Mode registers A and B and mode C bits 7:3 are kept. Buffer or counter writes made during that cycle are lost.
- R7: Writing 1 to mode C bit 0 (single step) makes the bit read 1 for the following cycle. At the end of that cycle the counter increments by one and the bit returns to 0. `tck_pulse` is not raised by the step.
- R8: When soft reset is written together with status refresh or single step, only the soft reset runs. The other two bits read 0 and have no effect.
- R9: While mode A bit 0 is 1 and no soft reset is pending, `tck_pulse` equals `cnt_tick` and each tick cycle increments the counter. A tick and a step in the same cycle add one in total. A counter byte write in that cycle takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc | input | 1 | Register access strobe |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cnt_tick | input | 1 | Counting event from the scan engine |
| tck_pulse | output | 1 | Scan clock pulse request |
| upd_pulse | output | 1 | Status refresh pulse |
| tdo_buf | output | 8 | Scan-data-out buffer |
| tms0_buf | output | 8 | Mode-select stream 0 buffer |
| tms1_buf | output | 8 | Mode-select stream 1 buffer |

## Verification
The checker watches four things on every cycle:
- soft reset excludes the other commands, and the counter and pointer are zero after it
- a lone step increments the counter by exactly one
- a refresh command falls back to idle unless it is rewritten
- `tck_pulse` only follows a tick, and the status bit never reads as 1.

Only the bench's scenarios can show the rest:
- the asymmetric read and write maps
- the byte-lane order and pointer wrap
- readback capture timing
- the fact that mode registers survive soft reset.

The bench shows these by comparing every read against a cycle model.

// File: rtl/tap_regs_pkg.sv
package tap_regs_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    SLOT_0 = 3'd0,
    SLOT_1 = 3'd1,
    SLOT_2 = 3'd2,
    SLOT_3 = 3'd3,
    SLOT_4 = 3'd4,
    SLOT_MA = 3'd5,
    SLOT_MB = 3'd6,
    SLOT_MC = 3'd7
  } slot_e;

  // command bit positions inside mode C (read back by the host)
  localparam int unsigned CMD_STEP = 0;
  localparam int unsigned CMD_SRST = 1;
  localparam int unsigned CMD_UPD = 2;
  localparam int unsigned CMD_N = 3;
endpackage

// File: rtl/tap_regs_cmd.sv
module tap_regs_cmd
  import tap_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mc,
  input  logic [BYTE_W-1:0] wdata,
  output logic              step_q,
  output logic              srst_q,
  output logic              upd_q,
  output logic [BYTE_W-1:0] mc_read
);
  localparam int unsigned HI_W = BYTE_W - CMD_N;

  logic [HI_W-1:0] mc_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_hi  <= '0;
      step_q <= 1'b0;
      srst_q <= 1'b0;
      upd_q  <= 1'b0;
    end else if (wr_mc) begin
      mc_hi  <= wdata[BYTE_W-1:CMD_N];
      srst_q <= wdata[CMD_SRST];
      step_q <= wdata[CMD_STEP] & ~wdata[CMD_SRST];
      upd_q  <= wdata[CMD_UPD] & ~wdata[CMD_SRST];
    end else begin
      step_q <= 1'b0;
      srst_q <= 1'b0;
      upd_q  <= 1'b0;
    end
  end

  always_comb begin
    mc_read = {mc_hi, {CMD_N{1'b0}}};
    mc_read[CMD_SRST] = srst_q;
    mc_read[CMD_STEP] = step_q;
  end
endmodule

// File: rtl/tap_regs_counter.sv
module tap_regs_counter
  import tap_regs_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lane,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              inc,
  output logic [CNT_W-1:0]  count,
  output logic [$clog2(CNT_W/BYTE_W)-1:0] ptr
);
  localparam int unsigned LANES = CNT_W / BYTE_W;
  localparam int unsigned PTR_W = $clog2(LANES);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LANES - 1);

  logic [CNT_W-1:0] written;
  logic [CNT_W-1:0] count_d;
  logic [PTR_W-1:0] ptr_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign written[g*BYTE_W +: BYTE_W] =
      (ptr == PTR_W'(g)) ? wdata : count[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    count_d = count;
    ptr_d   = ptr;
    if (clr) begin
      count_d = '0;
      ptr_d   = '0;
    end else if (wr_lane) begin
      count_d = written;
      ptr_d   = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end else if (inc) begin
      count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ptr   <= '0;
    end else begin
      count <= count_d;
      ptr   <= ptr_d;
    end
  end
endmodule

// File: rtl/tap_host_regs.sv
module tap_host_regs
  import tap_regs_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cnt_tick,
  output logic              tck_pulse,
  output logic              upd_pulse,
  output logic [BYTE_W-1:0] tdo_buf,
  output logic [BYTE_W-1:0] tms0_buf,
  output logic [BYTE_W-1:0] tms1_buf
);
  localparam int unsigned LANES = CNT_W / BYTE_W;
  localparam int unsigned PTR_W = $clog2(LANES);

  logic              wr;
  logic              step_q, srst_q, upd_q;
  logic [BYTE_W-1:0] mc_read;
  logic [BYTE_W-1:0] tdi_buf, mode_a, mode_b;
  logic [CNT_W-1:0]  count, snap;
  logic [PTR_W-1:0]  ptr;
  logic              count_en;

  assign wr = acc & ~rnw;
  assign count_en = mode_a[0] & ~srst_q;
  assign tck_pulse = cnt_tick & count_en;
  assign upd_pulse = upd_q;

  tap_regs_cmd u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mc  (wr && addr == SLOT_MC),
    .wdata  (wdata),
    .step_q (step_q),
    .srst_q (srst_q),
    .upd_q  (upd_q),
    .mc_read(mc_read)
  );

  tap_regs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (srst_q),
    .wr_lane(wr && addr == SLOT_4),
    .wdata  (wdata),
    .inc    (step_q | (cnt_tick & count_en)),
    .count  (count),
    .ptr    (ptr)
  );

  // host bank: survives soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a <= '0;
      mode_b <= '0;
    end else if (wr) begin
      if (addr == SLOT_MA) mode_a <= wdata;
      if (addr == SLOT_MB) mode_b <= wdata;
    end
  end

  // scan-side buffers and readback: cleared by soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_buf  <= '0;
      tdi_buf  <= '0;
      tms0_buf <= '0;
      tms1_buf <= '0;
      snap     <= '0;
    end else if (srst_q) begin
      tdo_buf  <= '0;
      tdi_buf  <= '0;
      tms0_buf <= '0;
      tms1_buf <= '0;
      snap     <= '0;
    end else begin
      if (upd_q) snap <= count;
      if (wr) begin
        case (addr)
          SLOT_0:  tdo_buf  <= wdata;
          SLOT_1:  tdi_buf  <= wdata;
          SLOT_2:  tms0_buf <= wdata;
          SLOT_3:  tms1_buf <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      SLOT_0:  rdata = snap[1*BYTE_W +: BYTE_W];
      SLOT_1:  rdata = tdi_buf;
      SLOT_2:  rdata = snap[2*BYTE_W +: BYTE_W];
      SLOT_3:  rdata = snap[3*BYTE_W +: BYTE_W];
      SLOT_4:  rdata = snap[0 +: BYTE_W];
      SLOT_MA: rdata = mode_a;
      SLOT_MB: rdata = mode_b;
      default: rdata = mc_read;
    endcase
  end
endmodule

// File: rtl/tap_host_regs_chk.sv
module tap_host_regs_chk
  import tap_regs_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic              rnw,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              cnt_tick,
  input logic              tck_pulse,
  input logic              step_q,
  input logic              srst_q,
  input logic              upd_q,
  input logic [CNT_W-1:0]  count,
  input logic [$clog2(CNT_W/BYTE_W)-1:0] ptr
);
  logic wr_mc;
  logic wr_cnt;

  assign wr_mc  = acc && !rnw && addr == SLOT_MC;
  assign wr_cnt = acc && !rnw && addr == SLOT_4;

  a_r6_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (count == '0 && ptr == '0));

  a_r7_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && !srst_q && !wr_cnt) |=> count == $past(count) + 1'b1);

  a_r8_srst_alone: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (!step_q && !upd_q));

  a_r5_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !wr_mc) |=> !upd_q);

  a_r9_tck_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tck_pulse |-> cnt_tick);

  a_r5_upd_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SLOT_MC) |-> rdata[CMD_UPD] == 1'b0);
endmodule

bind tap_host_regs tap_host_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc      (acc),
  .rnw      (rnw),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .cnt_tick (cnt_tick),
  .tck_pulse(tck_pulse),
  .step_q   (step_q),
  .srst_q   (srst_q),
  .upd_q    (upd_q),
  .count    (count),
  .ptr      (ptr)
);

// File: tb/test_tap_host_regs.sv
module test_tap_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc = 1'b0, rnw = 1'b0, cnt_tick = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tdo_buf, tms0_buf, tms1_buf;
  logic       tck_pulse, upd_pulse;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [31:0] m_cnt, m_snap;
  logic [1:0]  m_ptr;
  logic [7:0]  m_tdo, m_tdi, m_tms0, m_tms1, m_ma, m_mb;
  logic [4:0]  m_mchi;
  logic        m_step, m_srst, m_upd;

  always #4 clk = ~clk;

  tap_host_regs i_tap_host_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .rnw(rnw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_tick(cnt_tick),
    .tck_pulse(tck_pulse), .upd_pulse(upd_pulse),
    .tdo_buf(tdo_buf), .tms0_buf(tms0_buf), .tms1_buf(tms1_buf)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_snap[15:8];
      3'd1: return m_tdi;
      3'd2: return m_snap[23:16];
      3'd3: return m_snap[31:24];
      3'd4: return m_snap[7:0];
      3'd5: return m_ma;
      3'd6: return m_mb;
      default: return {m_mchi, 1'b0, m_srst, m_step};
    endcase
  endfunction

  task automatic m_reset();
    m_cnt = '0; m_snap = '0; m_ptr = '0;
    m_tdo = '0; m_tdi = '0; m_tms0 = '0; m_tms1 = '0;
    m_ma = '0; m_mb = '0; m_mchi = '0;
    m_step = 0; m_srst = 0; m_upd = 0;
  endtask

  task automatic m_edge(logic a_acc, logic a_rnw, logic [2:0] a, logic [7:0] d, logic t);
    logic wr = a_acc && !a_rnw;
    logic en = m_ma[0] && !m_srst;
    logic [31:0] c = m_cnt;
    if (wr && a == 5) m_ma = d;
    if (wr && a == 6) m_mb = d;
    if (m_srst) begin
      m_cnt = '0; m_ptr = '0; m_snap = '0;
      m_tdo = '0; m_tdi = '0; m_tms0 = '0; m_tms1 = '0;
    end else begin
      if (m_upd) m_snap = c;
      if (wr && a == 4) begin
        m_cnt[m_ptr*8 +: 8] = d;
        m_ptr = m_ptr + 2'd1;
      end else if (m_step || (t && en)) begin
        m_cnt = c + 1;
      end
      if (wr && a == 0) m_tdo = d;
      if (wr && a == 1) m_tdi = d;
      if (wr && a == 2) m_tms0 = d;
      if (wr && a == 3) m_tms1 = d;
    end
    if (wr && a == 7) begin
      m_mchi = d[7:3];
      m_srst = d[1];
      m_step = d[0] && !d[1];
      m_upd = d[2] && !d[1];
    end else begin
      m_srst = 0; m_step = 0; m_upd = 0;
    end
  endtask

  // one bus cycle: drive at negedge, check mid-cycle, advance model at edge
  task automatic cyc(string req, logic a_acc, logic a_rnw, logic [2:0] a,
                     logic [7:0] d, logic t);
    @(negedge clk);
    acc = a_acc; rnw = a_rnw; addr = a; wdata = d; cnt_tick = t;
    #1;
    if (a_acc && a_rnw) check(req, rdata, m_read(a));
    check("R9 tck", tck_pulse, t && m_ma[0] && !m_srst);
    check("R5 upd", upd_pulse, m_upd);
    check("R2 bufs", {tdo_buf, tms0_buf, tms1_buf}, {m_tdo, m_tms0, m_tms1});
    @(posedge clk);
    m_edge(a_acc, a_rnw, a, d, t);
  endtask

  task automatic rd(string req, logic [2:0] a);
    cyc(req, 1, 1, a, 8'h00, 0);
  endtask

  task automatic wrt(logic [2:0] a, logic [7:0] d);
    cyc("R2", 1, 0, a, d, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a));

    // R2/R3: write map and asymmetric read map
    wrt(0, 8'h11); wrt(1, 8'h22); wrt(2, 8'h33); wrt(3, 8'h44);
    wrt(5, 8'h01); wrt(6, 8'h66);
    for (int a = 0; a < 8; a++) rd("R3", 3'(a));

    // R4: lane order and pointer wrap, then R5 capture
    wrt(4, 8'hA0); wrt(4, 8'hB1); wrt(4, 8'hC2); wrt(4, 8'hD3);
    wrt(4, 8'hE4);
    wrt(7, 8'h04);
    rd("R5 bit2 zero", 7);
    for (int a = 0; a < 5; a++) rd("R4", 3'(a));

    // R7: step, bit visible one cycle; then R9 tick+step together
    wrt(5, 8'h00);
    wrt(7, 8'h01);
    rd("R7 step bit", 7);
    rd("R7 step clear", 7);
    wrt(7, 8'h04); rd("R7 value", 4);
    wrt(5, 8'h01);
    wrt(7, 8'h01);
    cyc("R9 tick+step", 0, 1, 0, 0, 1);
    wrt(7, 8'h04); rd("R9 value", 4);

    // R8: srst with step and update; R6 modes kept
    wrt(7, 8'hFF);
    cyc("R6 srst bit", 1, 1, 7, 0, 1);
    for (int a = 0; a < 8; a++) rd("R6", 3'(a));
    wrt(7, 8'h04);
    rd("R8 value", 4);

    // R6: buffer write during reset cycle is lost
    wrt(0, 8'h5A);
    wrt(7, 8'h02);
    cyc("R6 lost", 1, 0, 0, 8'h77, 0);
    rd("R6 after", 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [2:0] a = r[2:0];
      logic [7:0] d = r[15:8];
      if (a == 7 && r[16]) d[1] = 1'b0;
      cyc("R3 random", r[20] | r[21], r[22], a, d, r[23]);
    end
    for (int a = 0; a < 8; a++) rd("R3 final", 3'(a));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule